// File: doc/BRIEF.md
# Descriptor-Table Trap Entry Sequencer

This block is the multi-cycle part of a CPU's exception path for a machine whose handler addresses live in an in-memory table of 8-byte gate entries. When the core raises a software trap or an exception, it hands the sequencer an 8-bit vector, the return PC and the current stack pointer. The sequencer first checks the vector against the table limit. It then reads the two words of the gate entry through a single word-wide memory port and checks the entry's valid flag. Next it saves flags, code segment and return PC on a stack that grows downward. Finally it issues one redirect pulse carrying the handler address and the updated stack pointer.

The same engine also performs the return path. It reads three words from the stack top, restores the code-segment and flags registers it owns, and redirects to the popped PC. A third operation loads the table base and limit register in a single cycle. While an operation is in flight the block reports busy and drops any other request. For a software trap, the core passes the address of the following instruction as the return PC.

Top module: `gate_trap_seq`

## Requirements
- R1: After reset, busy, done, err and mem_req are low, cur_cs reads 8 and cur_flags reads 0x2.
- R2: req_op encodes 0 = trap entry, 1 = return, 2 = load table register, 3 = no operation. A request is taken only when req_valid is high while busy is low. Code 3 starts nothing and makes no memory access.
- R3: A trap reads the word at base + vector*8 + 4 first, then the word at base + vector*8. The handler address is bits 31..16 of the first word joined with bits 15..0 of the second word. Every other entry bit is ignored.
- R4: If bit 15 of the first entry word is clear, err pulses for one cycle in the cycle after that read. No stack write follows.
- R5: If vector*8 + 7 is greater than the table limit, err pulses in the cycle after acceptance and no memory access is made.
- R6: A good trap writes cur_flags at sp-4, then cur_cs at sp-8, then the return PC at sp-12. After that, done pulses with redir_pc set to the handler address and new_sp set to sp-12.
- R7: A return reads the PC from sp, the code segment from sp+4 and the flags from sp+8. It loads cur_cs and cur_flags from those reads, then pulses done with redir_pc set to the popped PC and new_sp set to sp+12.
- R8: The load-table operation writes base (ld_base) and limit (ld_limit) at the accepting edge. The limit is 0 after reset, so every trap faults until a table is loaded.
- R9: busy rises at the accepting edge and stays high through the done or err cycle. Requests seen while busy are dropped with no effect on the running operation.
- R10: With mem_ready held high, done or err is first seen this many clock edges after the accepting edge, counting that edge as 1: a good trap takes 6, a return takes 4, a limit fault takes 1 and an absent-entry fault takes 2.
- R11: While mem_req is high and mem_ready is low, address, write enable and write data hold steady. done and err never coincide and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 2 | Operation code (R2) |
| req_vec | input | 8 | Trap vector |
| req_pc | input | 32 | Return PC to save on trap |
| req_sp | input | 32 | Stack pointer at request |
| ld_base | input | 32 | Table base for load operation |
| ld_limit | input | 16 | Table limit (last valid byte offset) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Redirect pulse |
| err | output | 1 | Trap fault pulse |
| redir_pc | output | 32 | Redirect target, valid with done |
| new_sp | output | 32 | Updated stack pointer, valid with done |
| cur_cs | output | 32 | Code-segment register |
| cur_flags | output | 32 | Flags register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, sampled when mem_ready is high |
| mem_ready | input | 1 | Access completes this cycle |

## Verification
The checker watches a few rules on every cycle. It holds memory requests stable through stalls. It keeps done and err exclusive and one cycle long. It holds busy until an operation ends. It also checks that a limit violation or an absent entry is followed by err with no memory request. Everything else comes only from the bench's sweeps over vectors, stack positions and stall patterns. That covers the handler assembly, the exact stack words and their addresses, the register restore on return, the cycle counts, and the table-reload effects.

// File: rtl/gts_pkg.sv
package gts_pkg;
  localparam int XW         = 32;
  localparam int VW         = 8;
  localparam int LW         = 16;
  localparam int ENT_SHIFT  = 3;
  localparam int PRES_BIT   = 15;
  localparam int HALF       = XW / 2;
  localparam logic [XW-1:0] WORD_BYTES = XW'(4);

  typedef enum logic [1:0] {
    OP_TRAP  = 2'd0,
    OP_IRET  = 2'd1,
    OP_LDTAB = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_HI, S_RD_LO, S_PUSH_F, S_PUSH_C, S_PUSH_P,
    S_POP_P, S_POP_C, S_POP_F, S_FIN, S_FAULT
  } st_e;

  function automatic logic [XW-1:0] entry_addr(input logic [XW-1:0] base,
                                               input logic [VW-1:0] vec);
    return base + {{(XW-VW-ENT_SHIFT){1'b0}}, vec, {ENT_SHIFT{1'b0}}};
  endfunction

  function automatic logic entry_fits(input logic [VW-1:0] vec,
                                      input logic [LW-1:0] lim);
    logic [LW:0] last;
    last = {{(LW+1-VW-ENT_SHIFT){1'b0}}, vec, {ENT_SHIFT{1'b1}}};
    return last <= {1'b0, lim};
  endfunction

  function automatic logic [XW-1:0] join_handler(input logic [HALF-1:0] upper,
                                                 input logic [XW-1:0] lo_word);
    return {upper, lo_word[HALF-1:0]};
  endfunction

  function automatic logic [XW-1:0] slot(input logic [XW-1:0] sp,
                                         input int k);
    return sp + XW'(k) * WORD_BYTES;
  endfunction
endpackage

// File: rtl/gts_table_reg.sv
module gts_table_reg
  import gts_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [XW-1:0] base_in,
  input  logic [LW-1:0] lim_in,
  output logic [XW-1:0] base,
  output logic [LW-1:0] lim
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      lim  <= '0;
    end else if (ld) begin
      base <= base_in;
      lim  <= lim_in;
    end
  end
endmodule

// File: rtl/gts_sys_regs.sv
module gts_sys_regs
  import gts_pkg::*;
#(
  parameter logic [XW-1:0] CS_RESET    = 32'd8,
  parameter logic [XW-1:0] FLAGS_RESET = 32'h2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_we,
  input  logic          fl_we,
  input  logic [XW-1:0] wdata,
  output logic [XW-1:0] cs,
  output logic [XW-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs    <= CS_RESET;
      flags <= FLAGS_RESET;
    end else begin
      if (cs_we) cs    <= wdata;
      if (fl_we) flags <= wdata;
    end
  end
endmodule

// File: rtl/gts_seq_fsm.sv
module gts_seq_fsm
  import gts_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [VW-1:0] req_vec,
  input  logic [XW-1:0] req_pc,
  input  logic [XW-1:0] req_sp,
  input  logic [XW-1:0] tbl_base,
  input  logic [LW-1:0] tbl_lim,
  input  logic [XW-1:0] cur_cs,
  input  logic [XW-1:0] cur_flags,
  input  logic [XW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [XW-1:0] redir_pc,
  output logic [XW-1:0] new_sp,
  output logic          mem_req,
  output logic          mem_we,
  output logic [XW-1:0] mem_addr,
  output logic [XW-1:0] mem_wdata,
  output logic          tbl_ld,
  output logic          cs_we,
  output logic          fl_we,
  output logic          rd_hi_fire,
  output logic          oob_evt
);
  st_e             st;
  logic            is_ret;
  logic [XW-1:0]   ent_q;
  logic [XW-1:0]   ret_pc_q;
  logic [XW-1:0]   sp_q;
  logic [XW-1:0]   tgt_q;
  logic [HALF-1:0] hi_q;
  logic            accept;
  logic            fire;

  assign accept = req_valid && (st == S_IDLE);
  assign fire   = mem_req && mem_ready;
  assign busy   = (st != S_IDLE);
  assign done   = (st == S_FIN);
  assign err    = (st == S_FAULT);
  assign tbl_ld = accept && (op_e'(req_op) == OP_LDTAB);
  assign oob_evt = accept && (op_e'(req_op) == OP_TRAP) && !entry_fits(req_vec, tbl_lim);
  assign rd_hi_fire = fire && (st == S_RD_HI);
  assign cs_we  = fire && (st == S_POP_C);
  assign fl_we  = fire && (st == S_POP_F);
  assign redir_pc = tgt_q;
  assign new_sp   = is_ret ? slot(sp_q, 3) : slot(sp_q, -3);

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      S_RD_HI:  mem_addr = ent_q + WORD_BYTES;
      S_RD_LO:  mem_addr = ent_q;
      S_PUSH_F: begin mem_we = 1'b1; mem_addr = slot(sp_q, -1); mem_wdata = cur_flags; end
      S_PUSH_C: begin mem_we = 1'b1; mem_addr = slot(sp_q, -2); mem_wdata = cur_cs;    end
      S_PUSH_P: begin mem_we = 1'b1; mem_addr = slot(sp_q, -3); mem_wdata = ret_pc_q;  end
      S_POP_P:  mem_addr = sp_q;
      S_POP_C:  mem_addr = slot(sp_q, 1);
      S_POP_F:  mem_addr = slot(sp_q, 2);
      default:  mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      is_ret   <= 1'b0;
      ent_q    <= '0;
      ret_pc_q <= '0;
      sp_q     <= '0;
      tgt_q    <= '0;
      hi_q     <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          case (op_e'(req_op))
            OP_TRAP: begin
              is_ret   <= 1'b0;
              ent_q    <= entry_addr(tbl_base, req_vec);
              ret_pc_q <= req_pc;
              sp_q     <= req_sp;
              st       <= entry_fits(req_vec, tbl_lim) ? S_RD_HI : S_FAULT;
            end
            OP_IRET: begin
              is_ret <= 1'b1;
              sp_q   <= req_sp;
              st     <= S_POP_P;
            end
            default: st <= S_IDLE;
          endcase
        end
        S_RD_HI: if (fire) begin
          hi_q <= mem_rdata[XW-1:HALF];
          st   <= mem_rdata[PRES_BIT] ? S_RD_LO : S_FAULT;
        end
        S_RD_LO: if (fire) begin
          tgt_q <= join_handler(hi_q, mem_rdata);
          st    <= S_PUSH_F;
        end
        S_PUSH_F: if (fire) st <= S_PUSH_C;
        S_PUSH_C: if (fire) st <= S_PUSH_P;
        S_PUSH_P: if (fire) st <= S_FIN;
        S_POP_P: if (fire) begin
          tgt_q <= mem_rdata;
          st    <= S_POP_C;
        end
        S_POP_C: if (fire) st <= S_POP_F;
        S_POP_F: if (fire) st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gate_trap_seq.sv
module gate_trap_seq
  import gts_pkg::*;
#(
  parameter logic [31:0] CS_RESET    = 32'd8,
  parameter logic [31:0] FLAGS_RESET = 32'h2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [7:0]  req_vec,
  input  logic [31:0] req_pc,
  input  logic [31:0] req_sp,
  input  logic [31:0] ld_base,
  input  logic [15:0] ld_limit,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] redir_pc,
  output logic [31:0] new_sp,
  output logic [31:0] cur_cs,
  output logic [31:0] cur_flags,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready
);
  logic [XW-1:0] tbl_base;
  logic [LW-1:0] tbl_lim;
  logic          tbl_ld;
  logic          cs_we;
  logic          fl_we;
  logic          rd_hi_fire;
  logic          oob_evt;

  gts_table_reg u_tbl (
    .clk(clk), .rst_n(rst_n), .ld(tbl_ld),
    .base_in(ld_base), .lim_in(ld_limit),
    .base(tbl_base), .lim(tbl_lim)
  );

  gts_sys_regs #(.CS_RESET(CS_RESET), .FLAGS_RESET(FLAGS_RESET)) u_sys (
    .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .fl_we(fl_we),
    .wdata(mem_rdata), .cs(cur_cs), .flags(cur_flags)
  );

  gts_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_vec(req_vec),
    .req_pc(req_pc), .req_sp(req_sp),
    .tbl_base(tbl_base), .tbl_lim(tbl_lim),
    .cur_cs(cur_cs), .cur_flags(cur_flags),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .err(err),
    .redir_pc(redir_pc), .new_sp(new_sp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .tbl_ld(tbl_ld), .cs_we(cs_we), .fl_we(fl_we),
    .rd_hi_fire(rd_hi_fire), .oob_evt(oob_evt)
  );
endmodule

// File: rtl/gts_checks.sv
module gts_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_rdata,
  input logic        rd_hi_fire,
  input logic        oob_evt
);
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err && !busy);

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && !err |=> busy);

  a_r9_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  a_r4_absent_faults: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi_fire && !mem_rdata[15] |=> err && !mem_req);

  a_r5_oob_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    oob_evt |=> err && !mem_req);

  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
endmodule

bind gate_trap_seq gts_checks u_chk (.*);

// File: tb/gate_trap_seq_tb.sv
module gate_trap_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd3;
  logic [7:0]  req_vec = '0;
  logic [31:0] req_pc = '0, req_sp = '0, ld_base = '0;
  logic [15:0] ld_limit = '0;
  logic        busy, done, err, mem_req, mem_we;
  logic [31:0] redir_pc, new_sp, cur_cs, cur_flags, mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b1;
  logic        stall = 1'b0;

  logic [31:0] m [0:255];
  int rd_cnt = 0, wr_cnt = 0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gate_trap_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_vec(req_vec), .req_pc(req_pc), .req_sp(req_sp),
    .ld_base(ld_base), .ld_limit(ld_limit),
    .busy(busy), .done(done), .err(err), .redir_pc(redir_pc), .new_sp(new_sp),
    .cur_cs(cur_cs), .cur_flags(cur_flags),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  assign mem_rdata = m[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        m[mem_addr[9:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  always @(negedge clk) mem_ready <= stall ? ~mem_ready : 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] hi16(input int v); return 16'h4000 + 16'(v * 'h0103); endfunction
  function automatic logic [15:0] lo16(input int v); return 16'h8000 ^ 16'(v * 'h0123); endfunction
  function automatic bit present(input int v); return (v % 5) != 3; endfunction

  task automatic run_op(input logic [1:0] op, input logic [7:0] vec,
                        input logic [31:0] pc, input logic [31:0] sp,
                        output int cnt);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_vec = vec; req_pc = pc; req_sp = sp;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd3;
    cnt = 1;
    while (!(done || err) && cnt < 300) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic load_tab(input logic [31:0] b, input logic [15:0] l);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2; ld_base = b; ld_limit = l;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd3;
  endtask

  initial begin
    int cycles = 0;
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt, r0, w0;
    logic [31:0] sp, pc, hv;
    for (int i = 0; i < 256; i++) m[i] = 32'h0;
    for (int v = 0; v < 40; v++) begin
      m[(32'h100 + v*8) >> 2]     = {16'hDEAD, lo16(v)};
      m[(32'h100 + v*8 + 4) >> 2] = {hi16(v), present(v) ? 1'b1 : 1'b0, 15'h7ABC};
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !err && !mem_req, "R1", "idle outputs", {28'h0, busy, done, err, mem_req}, 32'h0);
    check(cur_cs == 32'd8, "R1", "cs reset", cur_cs, 32'd8);
    check(cur_flags == 32'h2, "R1", "flags reset", cur_flags, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 limit is zero after reset: vector 0 faults with no access
    r0 = rd_cnt;
    run_op(2'd0, 8'd0, 32'h10, 32'h3F0, cnt);
    check(err && cnt == 1, "R8", "fault before table load", {31'h0, err}, 32'h1);
    check(rd_cnt == r0, "R8", "no reads before load", rd_cnt, r0);

    load_tab(32'h100, 16'd255);

    // R3 R4 R5 R6 R10 sweep over vectors
    for (int v = 0; v < 40; v++) begin
      stall = (v % 2) == 1;
      sp = 32'h3F0 - (v % 4) * 16;
      pc = 32'h1000 + v * 4;
      r0 = rd_cnt; w0 = wr_cnt;
      run_op(2'd0, 8'(v), pc, sp, cnt);
      stall = 1'b0;
      if (v * 8 + 7 > 255) begin
        check(err && !done, "R5", "limit fault", {30'h0, done, err}, 32'h1);
        check(rd_cnt == r0 && wr_cnt == w0, "R5", "no access on limit fault", rd_cnt - r0 + wr_cnt - w0, 0);
        if (!((v % 2) == 1)) check(cnt == 1, "R10", "limit fault latency", cnt, 1);
      end else if (!present(v)) begin
        check(err && !done, "R4", "absent fault", {30'h0, done, err}, 32'h1);
        check(wr_cnt == w0 && rd_cnt == r0 + 1, "R4", "one read no write", wr_cnt - w0, 0);
        if (!((v % 2) == 1)) check(cnt == 2, "R10", "absent fault latency", cnt, 2);
      end else begin
        hv = {hi16(v), lo16(v)};
        check(done && !err, "R6", "done pulse", {30'h0, done, err}, 32'h2);
        check(redir_pc == hv, "R3", "handler address", redir_pc, hv);
        check(new_sp == sp - 12, "R6", "new sp", new_sp, sp - 12);
        check(m[(sp - 4) >> 2] == 32'h2, "R6", "pushed flags", m[(sp - 4) >> 2], 32'h2);
        check(m[(sp - 8) >> 2] == 32'd8, "R6", "pushed cs", m[(sp - 8) >> 2], 32'd8);
        check(m[(sp - 12) >> 2] == pc, "R6", "pushed pc", m[(sp - 12) >> 2], pc);
        check(rd_cnt == r0 + 2 && wr_cnt == w0 + 3, "R6", "access count", rd_cnt - r0, 2);
        if (!((v % 2) == 1)) check(cnt == 6, "R10", "trap latency", cnt, 6);
      end
    end

    // R5 limit boundary: limit 254 rejects vector 31
    load_tab(32'h100, 16'd254);
    run_op(2'd0, 8'd31, 32'h40, 32'h3F0, cnt);
    check(err, "R5", "vector 31 over limit 254", {31'h0, err}, 32'h1);
    run_op(2'd0, 8'd30, 32'h40, 32'h3F0, cnt);
    check(done && redir_pc == {hi16(30), lo16(30)}, "R5", "vector 30 within limit 254", redir_pc, {hi16(30), lo16(30)});

    // R8 new base shifts the entry: base+8, vector 0 uses entry 1
    load_tab(32'h108, 16'd255);
    run_op(2'd0, 8'd0, 32'h44, 32'h3F0, cnt);
    check(done && redir_pc == {hi16(1), lo16(1)}, "R8", "rebased table", redir_pc, {hi16(1), lo16(1)});

    // R7 return restores registers
    m[32'h300 >> 2] = 32'h0234_5678;
    m[32'h304 >> 2] = 32'h0000_001B;
    m[32'h308 >> 2] = 32'h0000_0246;
    run_op(2'd1, 8'd0, 32'h0, 32'h300, cnt);
    check(done && redir_pc == 32'h0234_5678, "R7", "popped pc", redir_pc, 32'h0234_5678);
    check(new_sp == 32'h30C, "R7", "return sp", new_sp, 32'h30C);
    check(cnt == 4, "R10", "return latency", cnt, 4);
    @(negedge clk);
    check(cur_cs == 32'h1B, "R7", "restored cs", cur_cs, 32'h1B);
    check(cur_flags == 32'h246, "R7", "restored flags", cur_flags, 32'h246);

    // R6 pushes use current registers after restore
    load_tab(32'h100, 16'd255);
    run_op(2'd0, 8'd2, 32'h88, 32'h3E0, cnt);
    check(m[32'h3DC >> 2] == 32'h246, "R6", "pushed restored flags", m[32'h3DC >> 2], 32'h246);
    check(m[32'h3D8 >> 2] == 32'h1B, "R6", "pushed restored cs", m[32'h3D8 >> 2], 32'h1B);

    // R9 request during busy is dropped
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_vec = 8'd4; req_pc = 32'h500; req_sp = 32'h3F0;
    @(negedge clk);
    check(busy, "R9", "busy after accept", {31'h0, busy}, 32'h1);
    req_op = 2'd1; req_sp = 32'h300;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd3;
    cnt = 0;
    while (!done && cnt < 50) begin @(negedge clk); cnt++; end
    check(redir_pc == {hi16(4), lo16(4)}, "R9", "running trap unaffected", redir_pc, {hi16(4), lo16(4)});
    r0 = rd_cnt;
    repeat (4) @(negedge clk);
    check(!busy && !done && rd_cnt == r0, "R9", "dropped request left no work", rd_cnt - r0, 0);
    check(cur_cs == 32'h1B, "R9", "cs untouched", cur_cs, 32'h1B);

    // R2 code 3 does nothing
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    check(!busy && !mem_req, "R2", "no-op stays idle", {30'h0, busy, mem_req}, 32'h0);
    repeat (3) @(negedge clk);
    check(rd_cnt == r0 && wr_cnt == w0 && !done && !err, "R2", "no-op no access", rd_cnt - r0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule